// File: doc/BRIEF.md
# Shared-Line Pad Interrupt Aggregator

This block turns the conditioned input of every general-purpose pad into interrupt events. It then folds those events onto sixteen shared interrupt lines and raises one interrupt request to the host. Each pad brings four things to the block:

- its already-synchronized receive level;
- a 3-bit trigger code;
- an invert bit;
- a 4-bit line select.

The invert bit is applied first. Edge or level detection then works on the conditioned value. A detected event sets the pending bit of the line that the pad selects.

Software reaches the pending and enable bits through a plain single-cycle register port. A write takes effect at the next clock edge and is never stalled. Reads are combinational on the address. There is no handshake and no back-pressure.

A typical start-up sequence writes zero to the enable register and then writes all ones to the pending register. After that, software enables the lines it cares about. It services the interrupt by reading pending, handling the set bits, and writing them back as ones to clear them.

Top module: `gpio_irq_aggr`

## Requirements
- R1: After reset, the pending register, the enable register and `host_irq_o` are all zero.
- R2: The trigger codes select the event kind on the conditioned input: 1 fires on a 1-to-0 change, 2 on a 0-to-1 change, 3 on either change. An event sets its line's pending bit at the next clock edge. The opposite edge has no effect.
- R3: Trigger code 4 is level mode. The pending bit is set on every clock edge at which the conditioned input is 1, so a clear does not hold while the level persists.
- R4: The invert bit is XORed onto the receive input before detection. Level mode with invert set therefore fires while the pad is low, and rising mode with invert set fires on a falling pad.
- R5: Trigger codes 0, 5, 6 and 7 produce no events.
- R6: Bits [4p+3:4p] of the select bus route pad p to line 0..15. Events of pads that share a line are ORed into that line.
- R7: The pending register is at address 0x300, bits [15:0], one bit per line. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: When a set from an event and a software clear hit the same pending bit at the same edge, the bit stays set.
- R9: The enable register at address 0x380, bits [15:0], can be read and written. `host_irq_o` is 1 exactly when some line is both pending and enabled.
- R10: Bits [31:16] of both registers read as zero, and writing them has no effect. Any other address reads as zero and ignores writes.
- R11: No edge event is taken on the first clock edge after reset, because no earlier sample exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pad_rx_i | input | NUM_PADS | Synchronized receive level per pad |
| pad_trig_i | input | 3*NUM_PADS | Trigger code per pad, pad p at [3p+2:3p] |
| pad_inv_i | input | NUM_PADS | Receive invert per pad |
| pad_sel_i | input | 4*NUM_PADS | Line select per pad, pad p at [4p+3:4p] |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wr_en_i | input | 1 | Write strobe |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` |
| host_irq_o | output | 1 | Interrupt request to the host |

## Verification
The assertions check the following on every cycle:

- a set always wins over a clear of the same bit;
- written-one bits without a competing set are cleared;
- the enable register takes the written value;
- every detector's previous sample follows the conditioned input;
- disabled trigger codes stay silent;
- any pad event reaches some line.

Only the bench scenarios can show the rest. That covers which line a select actually picks, and the exact edge polarity under inversion. It also covers level re-assertion after a clear, the first-cycle edge suppression after reset, and the address decoding with its ignored upper bits.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int LINES  = 16;
  localparam int SEL_W  = $clog2(LINES);
  localparam int TRIG_W = 3;

  // Pending and enable register addresses (software-visible, fixed).
  localparam logic [15:0] PEND_OFS = 16'h0300;
  localparam logic [15:0] ENAB_OFS = 16'h0380;

  typedef enum logic [TRIG_W-1:0] {
    TRIG_OFF   = 3'd0,
    TRIG_FALL  = 3'd1,
    TRIG_RISE  = 3'd2,
    TRIG_BOTH  = 3'd3,
    TRIG_LEVEL = 3'd4
  } trig_e;

endpackage

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic [TRIG_W-1:0] trig_i,
  input  logic              inv_i,
  output logic              evt_o
);

  logic cond;
  logic prev_q;
  logic primed_q;

  // Inversion comes before any detection.
  assign cond = rx_i ^ inv_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= cond;
      primed_q <= 1'b1;
    end
  end

  always_comb begin
    evt_o = 1'b0;
    case (trig_e'(trig_i))
      TRIG_FALL:  evt_o = primed_q &  prev_q & ~cond;
      TRIG_RISE:  evt_o = primed_q & ~prev_q &  cond;
      TRIG_BOTH:  evt_o = primed_q & (prev_q ^ cond);
      TRIG_LEVEL: evt_o = cond;
      default:    evt_o = 1'b0;
    endcase
  end

  // R2
  prev_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (prev_q == $past(cond)));

  // R5
  silent_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig_i == 3'd0) || (trig_i > 3'd4)) |-> !evt_o);

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PADS = 8
) (
  input  logic [NUM_PADS-1:0]       pad_evt_i,
  input  logic [NUM_PADS*SEL_W-1:0] pad_sel_i,
  output logic [LINES-1:0]          line_set_o
);

  always_comb begin
    line_set_o = '0;
    for (int p = 0; p < NUM_PADS; p++) begin
      for (int l = 0; l < LINES; l++) begin
        if (pad_evt_i[p] && (pad_sel_i[p*SEL_W +: SEL_W] == SEL_W'(l)))
          line_set_o[l] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  line_set_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_en_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              host_irq_o
);

  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_OFS);
  localparam logic [ADDR_W-1:0] ENAB_A = ADDR_W'(ENAB_OFS);

  logic [LINES-1:0] pend_q;
  logic [LINES-1:0] enab_q;
  logic [LINES-1:0] wlo;
  logic [LINES-1:0] clr;
  logic             pend_wr;
  logic             enab_wr;
  logic             unused_hi;

  assign wlo       = reg_wdata_i[LINES-1:0];
  assign unused_hi = ^reg_wdata_i[DATA_W-1:LINES];
  assign pend_wr   = reg_wr_en_i && (reg_addr_i == PEND_A);
  assign enab_wr   = reg_wr_en_i && (reg_addr_i == ENAB_A);
  assign clr       = pend_wr ? wlo : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      enab_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | line_set_i;
      if (enab_wr) enab_q <= wlo;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == PEND_A)      reg_rdata_o[LINES-1:0] = pend_q;
    else if (reg_addr_i == ENAB_A) reg_rdata_o[LINES-1:0] = enab_q;
  end

  assign host_irq_o = |(pend_q & enab_q);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_set_i) |=> ((pend_q & $past(line_set_i)) == $past(line_set_i)));

  // R7
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_wr && (|(wlo & ~line_set_i))) |=> ((pend_q & $past(wlo & ~line_set_i)) == '0));

  // R9
  enab_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enab_wr |=> (enab_q == $past(wlo)));

endmodule

// File: rtl/gpio_irq_aggr.sv
module gpio_irq_aggr
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PADS = 8,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PADS-1:0]        pad_rx_i,
  input  logic [NUM_PADS*TRIG_W-1:0] pad_trig_i,
  input  logic [NUM_PADS-1:0]        pad_inv_i,
  input  logic [NUM_PADS*SEL_W-1:0]  pad_sel_i,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic                       reg_wr_en_i,
  input  logic [DATA_W-1:0]          reg_wdata_i,
  output logic [DATA_W-1:0]          reg_rdata_o,
  output logic                       host_irq_o
);

  logic [NUM_PADS-1:0] pad_evt;
  logic [LINES-1:0]    line_set;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    gpio_irq_detect u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .rx_i   (pad_rx_i[p]),
      .trig_i (pad_trig_i[p*TRIG_W +: TRIG_W]),
      .inv_i  (pad_inv_i[p]),
      .evt_o  (pad_evt[p])
    );
  end

  gpio_irq_router #(.NUM_PADS(NUM_PADS)) u_route (
    .pad_evt_i  (pad_evt),
    .pad_sel_i  (pad_sel_i),
    .line_set_o (line_set)
  );

  gpio_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_set_i  (line_set),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_en_i (reg_wr_en_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .host_irq_o  (host_irq_o)
  );

  // R6
  evt_reaches_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pad_evt) |-> (|line_set));

endmodule

// File: tb/tb_gpio_irq_aggr.sv
module tb_gpio_irq_aggr;

  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pad_rx = '0;
  logic [NP*3-1:0] pad_trig = '0;
  logic [NP-1:0] pad_inv = '0;
  logic [NP*4-1:0] pad_sel = '0;
  logic [11:0]   reg_addr = '0;
  logic          reg_wr_en = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          host_irq;

  int vectors = 0;
  int miscompares = 0;
  bit model_live = 0;

  always #4 clk = ~clk;

  gpio_irq_aggr #(.NUM_PADS(NP), .ADDR_W(12), .DATA_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .pad_rx_i(pad_rx), .pad_trig_i(pad_trig),
    .pad_inv_i(pad_inv), .pad_sel_i(pad_sel), .reg_addr_i(reg_addr),
    .reg_wr_en_i(reg_wr_en), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .host_irq_o(host_irq)
  );

  // Behavioural reference model
  logic [15:0] m_pend = '0;
  logic [15:0] m_enab = '0;
  bit          m_prev [NP];
  bit          m_primed = 0;

  always @(posedge clk) begin
    logic [15:0] hits;
    logic [15:0] wipe;
    model_live <= 1;
    if (!rst_n) begin
      m_pend = '0; m_enab = '0; m_primed = 0;
      for (int p = 0; p < NP; p++) m_prev[p] = 0;
    end else begin
      hits = '0;
      for (int p = 0; p < NP; p++) begin
        bit c;
        bit h;
        int t;
        c = pad_rx[p] ^ pad_inv[p];
        t = int'(pad_trig[p*3 +: 3]);
        h = 0;
        if (t == 4) h = c;
        else if (m_primed && t == 1) h = m_prev[p] && !c;
        else if (m_primed && t == 2) h = !m_prev[p] && c;
        else if (m_primed && t == 3) h = m_prev[p] != c;
        if (h) hits[pad_sel[p*4 +: 4]] = 1'b1;
        m_prev[p] = c;
      end
      wipe = (reg_wr_en && reg_addr == 12'h300) ? reg_wdata[15:0] : 16'h0;
      if (reg_wr_en && reg_addr == 12'h380) m_enab = reg_wdata[15:0];
      m_pend = (m_pend & ~wipe) | hits;
      m_primed = 1;
    end
  end

  function automatic logic [31:0] model_rd(logic [11:0] a);
    if (a == 12'h300) return {16'h0, m_pend};
    if (a == 12'h380) return {16'h0, m_enab};
    return 32'h0;
  endfunction

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (model_live) begin
      vectors++;
      if (host_irq !== |(m_pend & m_enab)) begin
        miscompares++;
        $display("FAIL R9 host_irq actual=%0b expected=%0b", host_irq, |(m_pend & m_enab));
      end
      vectors++;
      if (reg_rdata !== model_rd(reg_addr)) begin
        miscompares++;
        $display("FAIL R7 rdata @%h actual=%h expected=%h", reg_addr, reg_rdata, model_rd(reg_addr));
      end
    end
  end

  task automatic setp(int p, logic [2:0] t, logic i, logic [3:0] s, logic r);
    @(posedge clk); #2;
    reg_wr_en = 0;
    pad_trig[p*3 +: 3] = t;
    pad_inv[p] = i;
    pad_sel[p*4 +: 4] = s;
    pad_rx[p] = r;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #2;
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic chk_rd(logic [11:0] a, logic [31:0] exp_d, logic exp_irq, string tag);
    @(posedge clk); #2;
    reg_wr_en = 0; reg_addr = a;
    @(negedge clk);
    vectors++;
    if (reg_rdata !== exp_d) begin
      miscompares++;
      $display("FAIL %s rdata @%h actual=%h expected=%h", tag, a, reg_rdata, exp_d);
    end
    vectors++;
    if (host_irq !== exp_irq) begin
      miscompares++;
      $display("FAIL %s host_irq actual=%0b expected=%0b", tag, host_irq, exp_irq);
    end
  endtask

  initial begin
    #(8 * 20000);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R11: pad 0 already high, rising mode, across reset release
    pad_trig[2:0] = 3'd2; pad_rx[0] = 1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    chk_rd(12'h300, 0, 0, "R1");
    chk_rd(12'h380, 0, 0, "R1");
    chk_rd(12'h300, 0, 0, "R11");
    setp(0, 3'd0, 0, 0, 0);

    // R2 rising, falling, both on pad 1 -> line 3
    setp(1, 3'd2, 0, 3, 0);
    setp(1, 3'd2, 0, 3, 1);
    chk_rd(12'h300, 32'h8, 0, "R2");
    wr(12'h300, 32'h8);
    chk_rd(12'h300, 0, 0, "R7");
    setp(1, 3'd1, 0, 3, 1);
    setp(1, 3'd1, 0, 3, 0);
    chk_rd(12'h300, 32'h8, 0, "R2");
    wr(12'h300, 32'h8);
    chk_rd(12'h300, 0, 0, "R2");
    setp(1, 3'd3, 0, 3, 1);
    chk_rd(12'h300, 32'h8, 0, "R2");
    wr(12'h300, 32'h8);
    chk_rd(12'h300, 0, 0, "R2");
    setp(1, 3'd3, 0, 3, 0);
    chk_rd(12'h300, 32'h8, 0, "R2");
    wr(12'h300, 32'h8);
    chk_rd(12'h300, 0, 0, "R2");
    setp(1, 3'd2, 0, 3, 1);
    chk_rd(12'h300, 32'h8, 0, "R2");
    wr(12'h300, 32'h8);
    chk_rd(12'h300, 0, 0, "R2");
    setp(1, 3'd2, 0, 3, 0);
    chk_rd(12'h300, 0, 0, "R2");
    setp(1, 3'd0, 0, 3, 0);

    // R5: silent codes on pad 2 -> line 4
    for (int t = 0; t < 8; t++) begin
      if (t == 0 || t > 4) begin
        setp(2, 3'(t), 0, 4, 1);
        setp(2, 3'(t), 0, 4, 0);
      end
    end
    chk_rd(12'h300, 0, 0, "R5");

    // R3 / R8: level on pad 3 -> line 5
    setp(3, 3'd4, 0, 5, 1);
    chk_rd(12'h300, 32'h20, 0, "R3");
    wr(12'h300, 32'h20);
    chk_rd(12'h300, 32'h20, 0, "R8");
    setp(3, 3'd4, 0, 5, 0);
    wr(12'h300, 32'h20);
    chk_rd(12'h300, 0, 0, "R3");

    // R4: inversion ahead of detection
    setp(3, 3'd0, 1, 5, 0);
    setp(3, 3'd4, 1, 5, 0);
    chk_rd(12'h300, 32'h20, 0, "R4");
    setp(3, 3'd4, 1, 5, 1);
    wr(12'h300, 32'h20);
    chk_rd(12'h300, 0, 0, "R4");
    setp(3, 3'd2, 1, 5, 1);
    setp(3, 3'd2, 1, 5, 0);
    chk_rd(12'h300, 32'h20, 0, "R4");
    wr(12'h300, 32'h20);
    chk_rd(12'h300, 0, 0, "R4");
    setp(3, 3'd0, 0, 5, 0);

    // R6: routing and sharing
    setp(4, 3'd2, 0, 9, 0);
    setp(5, 3'd2, 0, 9, 0);
    setp(6, 3'd2, 0, 15, 0);
    setp(7, 3'd2, 0, 0, 0);
    @(posedge clk); #2;
    pad_rx[7:4] = 4'hF;
    chk_rd(12'h300, 32'h8201, 0, "R6");

    // R7 / R10: selective clears, zero writes, upper bits
    wr(12'h300, 32'h1);
    chk_rd(12'h300, 32'h8200, 0, "R7");
    wr(12'h300, 32'h0);
    chk_rd(12'h300, 32'h8200, 0, "R7");
    wr(12'h300, 32'hFFFF_0000);
    chk_rd(12'h300, 32'h8200, 0, "R10");

    // R9: enable register and host request
    wr(12'h380, 32'h0200);
    chk_rd(12'h380, 32'h0200, 1, "R9");
    wr(12'h380, 32'h0001);
    chk_rd(12'h380, 32'h0001, 0, "R9");
    wr(12'h380, 32'hFFFF_FFFF);
    chk_rd(12'h380, 32'hFFFF, 1, "R10");
    wr(12'h100, 32'h0);
    chk_rd(12'h380, 32'hFFFF, 1, "R10");
    chk_rd(12'h304, 32'h0, 1, "R10");
    wr(12'h300, 32'h0200);
    chk_rd(12'h300, 32'h8000, 1, "R9");

    // Start-up style sequence
    wr(12'h380, 32'h0);
    wr(12'h300, 32'hFFFF);
    chk_rd(12'h300, 0, 0, "R7");
    chk_rd(12'h380, 0, 0, "R9");

    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule